// File: doc/BRIEF.md
# DMA Debug Breakpoint Status Unit

This block holds the debug status of a small DMA engine that runs up to sixteen tasks. It compares each transfer address against a programmed breakpoint. Before the match, the breakpoint is moved up to the next boundary of the current transfer size. It also records external breakpoint events and interrupt-taken events. Everything is collected in one 32-bit status word that software reads and writes over a simple register strobe.

An internal breakpoint match marks the unit as triggered. In the same edge it marks the running task as blocked. While the unit is triggered, or the running task is blocked, the unit asks the engine to halt. Software releases the halt by writing ones to the sticky bits it wants cleared. In the status word, bit index 31 is the most significant bit.

Top module: `dbg_status_unit`

## Requirements
- R1: Bits 31 to 19 of `reg_rdata` always read as zero. The layout is: bit 18 is the interrupt flag, bit 17 is the external flag, bit 16 is the trigger flag, and bit 15-n is the blocked flag of task n.
- R2: The interrupt flag (bit 18) is set by `irq_set` and cleared by `irq_clr`. When neither is active, a write loads it from `reg_wdata[18]`. `irq_set` takes priority over `irq_clr`, and `irq_clr` takes priority over a write.
- R3: The external flag (bit 17) sets on the edge after `ext_bp` is high. Writing 1 to bit 17 clears it. Writing 0 leaves it unchanged.
- R4: A task's blocked flag is cleared by writing 1 to its bit. Writing 0 leaves it unchanged.
- R5: A breakpoint match sets the trigger flag. In the same edge it sets the blocked flag of the task on `cur_task`.
- R6: A match requires `bp_en`, `xfer_valid`, and `xfer_addr` equal to `bp_addr` rounded up to a multiple of the transfer size. The size encoding on `xfer_size` is: 0 for 1 byte, 1 for 2 bytes, 2 or 3 for 4 bytes. An aligned `bp_addr` matches itself.
- R7: Writing 1 to bit 16 clears the trigger flag. Writing 0 leaves it unchanged.
- R8: `halt_req` is high exactly while the trigger flag is set or the blocked flag of `cur_task` is set. It falls in the cycle after the write that clears those flags.
- R9: When a set event and a write-one clear hit the same sticky bit in the same cycle, the bit ends up set.
- R10: Asynchronous reset clears every bit of the status word and deasserts `halt_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bp_en | input | 1 | Breakpoint comparator enable |
| bp_addr | input | 16 | Breakpoint byte offset |
| xfer_size | input | 2 | Transfer size code (0: 1 B, 1: 2 B, 2/3: 4 B) |
| xfer_valid | input | 1 | A transfer is presented this cycle |
| xfer_addr | input | 16 | Byte offset of the current transfer |
| cur_task | input | 4 | Number of the running task |
| ext_bp | input | 1 | External breakpoint event |
| irq_set | input | 1 | Engine sets the interrupt flag |
| irq_clr | input | 1 | Engine clears the interrupt flag |
| reg_wr | input | 1 | Status register write strobe |
| reg_wdata | input | 32 | Status register write data |
| reg_rdata | output | 32 | Status register contents |
| halt_req | output | 1 | Halt request toward the engine |

## Verification
Every flag is visible on `reg_rdata` one edge after the event that moves it. A wrong set, a lost clear or a misplaced task bit therefore shows up as a wrong word on the very next cycle. A misrouted blocked bit also shows on `halt_req`, in that same cycle, when `cur_task` names the affected task. An error in the alignment logic appears as a missing or early trigger bit, one edge after the transfer that should, or should not, have matched. The same-cycle set and clear race is checked separately for the trigger and the external bit, because a clear-first ordering would lose the event without any other visible sign.

// File: rtl/dbg_stat_pkg.sv
package dbg_stat_pkg;
  localparam int NUM_TASKS = 16;
  localparam int TASK_W    = $clog2(NUM_TASKS);
  localparam int STAT_W    = 32;
  // lsb-indexed positions in the status word
  localparam int IDX_INTR  = NUM_TASKS + 2;
  localparam int IDX_EXT   = NUM_TASKS + 1;
  localparam int IDX_TRIG  = NUM_TASKS;
  localparam int STICKY_W  = NUM_TASKS + 2;
  localparam int RSVD_W    = STAT_W - STICKY_W - 1;

  typedef enum logic [1:0] {
    XS_BYTE  = 2'd0,
    XS_HALF  = 2'd1,
    XS_WORD  = 2'd2,
    XS_WORD3 = 2'd3
  } xsize_e;
endpackage

// File: rtl/dbg_align_cmp.sv
module dbg_align_cmp
  import dbg_stat_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              bp_en,
  input  logic [ADDR_W-1:0] bp_addr,
  input  logic [1:0]        xfer_size,
  input  logic              xfer_valid,
  input  logic [ADDR_W-1:0] xfer_addr,
  output logic              hit
);
  logic [ADDR_W-1:0] mask;
  logic [ADDR_W-1:0] aligned;

  always_comb begin
    unique case (xsize_e'(xfer_size))
      XS_BYTE: mask = ADDR_W'(0);
      XS_HALF: mask = ADDR_W'(1);
      default: mask = ADDR_W'(3);
    endcase
    aligned = (bp_addr + mask) & ~mask;
    hit     = bp_en && xfer_valid && (xfer_addr == aligned);
  end
endmodule

// File: rtl/dbg_sticky_bits.sv
module dbg_sticky_bits #(
  parameter int W = 18
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] q_o
);
  for (genvar k = 0; k < W; k++) begin : g_bit
    logic d;
    logic en;

    always_comb begin
      en = set_i[k] | clr_i[k];
      d  = set_i[k] | (q_o[k] & ~clr_i[k]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q_o[k] <= 1'b0;
      else if (en) q_o[k] <= d;
    end
  end
endmodule

// File: rtl/dbg_status_unit.sv
module dbg_status_unit
  import dbg_stat_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bp_en,
  input  logic [ADDR_W-1:0] bp_addr,
  input  logic [1:0]        xfer_size,
  input  logic              xfer_valid,
  input  logic [ADDR_W-1:0] xfer_addr,
  input  logic [TASK_W-1:0] cur_task,
  input  logic              ext_bp,
  input  logic              irq_set,
  input  logic              irq_clr,
  input  logic              reg_wr,
  input  logic [STAT_W-1:0] reg_wdata,
  output logic [STAT_W-1:0] reg_rdata,
  output logic              halt_req
);
  logic                 hit;
  logic [NUM_TASKS-1:0] task_set;
  logic [STICKY_W-1:0]  stk_set;
  logic [STICKY_W-1:0]  stk_clr;
  logic [STICKY_W-1:0]  stk_q;
  logic                 intr_q;
  logic                 intr_d;
  logic                 intr_en;
  logic                 blk_cur;

  dbg_align_cmp #(.ADDR_W(ADDR_W)) cmp_i (
    .bp_en      (bp_en),
    .bp_addr    (bp_addr),
    .xfer_size  (xfer_size),
    .xfer_valid (xfer_valid),
    .xfer_addr  (xfer_addr),
    .hit        (hit)
  );

  // task n owns lsb position NUM_TASKS-1-n
  for (genvar k = 0; k < NUM_TASKS; k++) begin : g_task
    assign task_set[k] = hit && (cur_task == TASK_W'(NUM_TASKS - 1 - k));
  end

  always_comb begin
    stk_set = {ext_bp, hit, task_set};
    stk_clr = reg_wr ? reg_wdata[STICKY_W-1:0] : '0;
  end

  dbg_sticky_bits #(.W(STICKY_W)) stk_i (
    .clk   (clk),
    .rst_n (rst_n),
    .set_i (stk_set),
    .clr_i (stk_clr),
    .q_o   (stk_q)
  );

  always_comb begin
    intr_en = irq_set | irq_clr | reg_wr;
    if (irq_set)      intr_d = 1'b1;
    else if (irq_clr) intr_d = 1'b0;
    else if (reg_wr)  intr_d = reg_wdata[IDX_INTR];
    else              intr_d = intr_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       intr_q <= 1'b0;
    else if (intr_en) intr_q <= intr_d;
  end

  always_comb begin
    blk_cur = 1'b0;
    for (int k = 0; k < NUM_TASKS; k++) begin
      if (cur_task == TASK_W'(NUM_TASKS - 1 - k)) blk_cur = stk_q[k];
    end
    halt_req  = stk_q[IDX_TRIG] | blk_cur;
    reg_rdata = {{RSVD_W{1'b0}}, intr_q, stk_q};
  end
endmodule

// File: rtl/dbg_status_chk.sv
module dbg_status_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        ext_bp,
  input logic        irq_set,
  input logic        reg_wr,
  input logic [31:0] reg_wdata,
  input logic [3:0]  cur_task,
  input logic        hit,
  input logic [31:0] reg_rdata,
  input logic        halt_req
);
  // R1
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[31:19] == 13'd0);

  // R2
  intr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_set |=> reg_rdata[18]);

  // R3
  ext_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ext_bp |=> reg_rdata[17]);

  // R3
  ext_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ext_bp && !(reg_wr && reg_wdata[17])) |=> $stable(reg_rdata[17]));

  // R5
  trig_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> (reg_rdata[16] && ((reg_rdata[15:0] & (16'h8000 >> $past(cur_task))) != 16'd0)));

  // R7
  trig_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_wdata[16] && !hit) |=> !reg_rdata[16]);

  // R8
  halt_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && (reg_wdata[16:0] == 17'h1FFFF) && !hit) |=> !halt_req);
endmodule

bind dbg_status_unit dbg_status_chk chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .ext_bp    (ext_bp),
  .irq_set   (irq_set),
  .reg_wr    (reg_wr),
  .reg_wdata (reg_wdata),
  .cur_task  (cur_task),
  .hit       (hit),
  .reg_rdata (reg_rdata),
  .halt_req  (halt_req)
);

// File: tb/dbg_status_unit_tb_top.sv
module dbg_status_unit_tb_top;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic        wr;
    logic [31:0] wdata;
    logic        ext;
    logic        iset;
    logic        iclr;
    logic        xv;
    logic [15:0] xa;
    logic [1:0]  sz;
    logic [15:0] bpa;
    logic        bpe;
    logic [3:0]  tsk;
    logic [31:0] exp_rd;
    logic        exp_halt;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 27;
  localparam vec_t VEC [NV] = '{
    // wr  wdata          ext   iset  iclr  xv    xa        sz     bpa       bpe   tsk    exp_rd        halt  req
    '{1'b0, 32'h0,        1'b0, 1'b0, 1'b0, 1'b1, 16'h0002, 2'd2, 16'h0002, 1'b1, 4'd3,  32'h0,        1'b0, 4'd6},  // R6 unaligned no hit
    '{1'b0, 32'h0,        1'b0, 1'b0, 1'b0, 1'b1, 16'h0004, 2'd2, 16'h0002, 1'b1, 4'd3,  32'h0001_1000, 1'b1, 4'd5},  // R5 round up hit
    '{1'b0, 32'h0,        1'b0, 1'b0, 1'b0, 1'b0, 16'h0000, 2'd2, 16'h0002, 1'b1, 4'd5,  32'h0001_1000, 1'b1, 4'd8},  // R8 T holds halt
    '{1'b1, 32'h0001_0000, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0000, 2'd2, 16'h0002, 1'b1, 4'd5,  32'h0000_1000, 1'b0, 4'd7},  // R7 clear T
    '{1'b0, 32'h0,        1'b0, 1'b0, 1'b0, 1'b0, 16'h0000, 2'd2, 16'h0002, 1'b1, 4'd3,  32'h0000_1000, 1'b1, 4'd8},  // R8 blocked task
    '{1'b1, 32'h0000_1000, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0000, 2'd2, 16'h0002, 1'b1, 4'd3,  32'h0,        1'b0, 4'd4},  // R4 clear blocked
    '{1'b0, 32'h0,        1'b1, 1'b0, 1'b0, 1'b0, 16'h0000, 2'd2, 16'h0002, 1'b1, 4'd3,  32'h0002_0000, 1'b0, 4'd3},  // R3 ext sets
    '{1'b1, 32'h0001_FFFF, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0000, 2'd2, 16'h0002, 1'b1, 4'd3,  32'h0002_0000, 1'b0, 4'd3},  // R3 write 0 no effect
    '{1'b1, 32'h0002_0000, 1'b1, 1'b0, 1'b0, 1'b0, 16'h0000, 2'd2, 16'h0002, 1'b1, 4'd3,  32'h0002_0000, 1'b0, 4'd9},  // R9 set wins
    '{1'b1, 32'h0002_0000, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0000, 2'd2, 16'h0002, 1'b1, 4'd3,  32'h0,        1'b0, 4'd3},  // R3 w1c
    '{1'b0, 32'h0,        1'b0, 1'b1, 1'b0, 1'b0, 16'h0000, 2'd2, 16'h0002, 1'b1, 4'd3,  32'h0004_0000, 1'b0, 4'd2},  // R2 engine set
    '{1'b1, 32'h0,        1'b0, 1'b0, 1'b0, 1'b0, 16'h0000, 2'd2, 16'h0002, 1'b1, 4'd3,  32'h0,        1'b0, 4'd2},  // R2 sw write 0
    '{1'b1, 32'h0004_0000, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0000, 2'd2, 16'h0002, 1'b1, 4'd3,  32'h0004_0000, 1'b0, 4'd2},  // R2 sw write 1
    '{1'b1, 32'h0,        1'b0, 1'b1, 1'b0, 1'b0, 16'h0000, 2'd2, 16'h0002, 1'b1, 4'd3,  32'h0004_0000, 1'b0, 4'd2},  // R2 engine over sw
    '{1'b0, 32'h0,        1'b0, 1'b0, 1'b1, 1'b0, 16'h0000, 2'd2, 16'h0002, 1'b1, 4'd3,  32'h0,        1'b0, 4'd2},  // R2 engine clear
    '{1'b0, 32'h0,        1'b0, 1'b0, 1'b0, 1'b1, 16'h0011, 2'd1, 16'h0011, 1'b1, 4'd0,  32'h0,        1'b0, 4'd6},  // R6 half no hit
    '{1'b0, 32'h0,        1'b0, 1'b0, 1'b0, 1'b1, 16'h0012, 2'd1, 16'h0011, 1'b1, 4'd0,  32'h0001_8000, 1'b1, 4'd5},  // R5 task0 bit15
    '{1'b1, 32'h0001_8000, 1'b0, 1'b0, 1'b0, 1'b1, 16'h0012, 2'd1, 16'h0011, 1'b1, 4'd15, 32'h0001_0001, 1'b1, 4'd9},  // R9 T kept
    '{1'b1, 32'h0001_0001, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0000, 2'd1, 16'h0011, 1'b1, 4'd15, 32'h0,        1'b0, 4'd8},  // R8 halt drops
    '{1'b0, 32'h0,        1'b0, 1'b0, 1'b0, 1'b1, 16'h0007, 2'd0, 16'h0007, 1'b1, 4'd7,  32'h0001_0100, 1'b1, 4'd6},  // R6 byte exact
    '{1'b1, 32'h0001_0100, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0000, 2'd0, 16'h0007, 1'b1, 4'd7,  32'h0,        1'b0, 4'd4},  // R4 clear
    '{1'b0, 32'h0,        1'b0, 1'b0, 1'b0, 1'b1, 16'h0007, 2'd0, 16'h0007, 1'b0, 4'd7,  32'h0,        1'b0, 4'd6},  // R6 disabled
    '{1'b0, 32'h0,        1'b0, 1'b0, 1'b0, 1'b1, 16'h0008, 2'd2, 16'h0008, 1'b1, 4'd15, 32'h0001_0001, 1'b1, 4'd6},  // R6 word aligned exact
    '{1'b1, 32'h0001_0001, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0000, 2'd2, 16'h0008, 1'b1, 4'd15, 32'h0,        1'b0, 4'd7},  // R7
    '{1'b0, 32'h0,        1'b0, 1'b0, 1'b0, 1'b1, 16'h0008, 2'd3, 16'h0005, 1'b1, 4'd1,  32'h0001_4000, 1'b1, 4'd6},  // R6 code 3 is 4B
    '{1'b1, 32'hFFF8_0000, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0000, 2'd3, 16'h0005, 1'b1, 4'd1,  32'h0001_4000, 1'b1, 4'd1},  // R1 reserved stay 0
    '{1'b1, 32'h0001_4000, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0000, 2'd3, 16'h0005, 1'b1, 4'd1,  32'h0,        1'b0, 4'd4}   // R4
  };

  logic        clk;
  logic        rst_n;
  logic        bp_en;
  logic [15:0] bp_addr;
  logic [1:0]  xfer_size;
  logic        xfer_valid;
  logic [15:0] xfer_addr;
  logic [3:0]  cur_task;
  logic        ext_bp;
  logic        irq_set;
  logic        irq_clr;
  logic        reg_wr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        halt_req;

  int checks;
  int failures;

  dbg_status_unit dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .bp_en      (bp_en),
    .bp_addr    (bp_addr),
    .xfer_size  (xfer_size),
    .xfer_valid (xfer_valid),
    .xfer_addr  (xfer_addr),
    .cur_task   (cur_task),
    .ext_bp     (ext_bp),
    .irq_set    (irq_set),
    .irq_clr    (irq_clr),
    .reg_wr     (reg_wr),
    .reg_wdata  (reg_wdata),
    .reg_rdata  (reg_rdata),
    .halt_req   (halt_req)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input logic [31:0] rd, input logic hl, input int req, input string what);
    checks++;
    if (reg_rdata !== rd || halt_req !== hl) begin
      failures++;
      $display("FAIL R%0d %s: rdata=%h halt=%b expected rdata=%h halt=%b",
               req, what, reg_rdata, halt_req, rd, hl);
    end
  endtask

  task automatic drive(input vec_t v);
    reg_wr     = v.wr;
    reg_wdata  = v.wdata;
    ext_bp     = v.ext;
    irq_set    = v.iset;
    irq_clr    = v.iclr;
    xfer_valid = v.xv;
    xfer_addr  = v.xa;
    xfer_size  = v.sz;
    bp_addr    = v.bpa;
    bp_en      = v.bpe;
    cur_task   = v.tsk;
  endtask

  task automatic idle();
    reg_wr = 1'b0; reg_wdata = '0; ext_bp = 1'b0; irq_set = 1'b0; irq_clr = 1'b0;
    xfer_valid = 1'b0; xfer_addr = '0; xfer_size = 2'd2; bp_addr = '0; bp_en = 1'b0; cur_task = '0;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    checks = 0;
    failures = 0;
    idle();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check(32'h0, 1'b0, 10, "reset state");  // R10
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i]);
      @(posedge clk);
      @(negedge clk);
      check(VEC[i].exp_rd, VEC[i].exp_halt, int'(VEC[i].req), $sformatf("vector %0d", i));
    end

    // R10: asynchronous reset clears live state
    drive('{1'b0, 32'h0, 1'b1, 1'b1, 1'b0, 1'b1, 16'h0004, 2'd2, 16'h0004, 1'b1, 4'd9,
            32'h0, 1'b0, 4'd10});
    @(posedge clk);
    @(negedge clk);
    check(32'h0007_0040, 1'b1, 5, "all flags set before reset");  // R5
    idle();
    #(CLK_PERIOD/4) rst_n = 1'b0;
    #1;
    check(32'h0, 1'b0, 10, "async reset");  // R10
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(32'h0, 1'b0, 10, "after reset release");  // R10

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule